// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with Event Input

This block is a 16-bit down counter with a companion reload register, one external input and one output. Software reaches it through a two-word register window. Address 0 is the control word. Address 1 holds the count, which is read-only, and the reload value, which is write-only. The counter steps on one of two kinds of source. The first is one of three prescaled internal clocks. The second is edges on the external input, which is event counting. With an internal clock selected, the external input can instead start a run on an edge or enable counting by its level, so it acts as a trigger or a gate.

A run begins in one of two ways: a software trigger, or an external trigger edge while the enable bit is set. At the start the reload value goes into the counter and the prescaler restarts. The counter passes below zero on the step that finds it at 0. That underflow reloads the counter and sets a sticky flag, which can raise an interrupt. With auto-reload set the run continues and the output toggles on every underflow. Without it the run ends, and the output is a pulse that lasts exactly as long as the run. The output can be inverted or held at its inactive level.

Two states control the counter. IDLE moves to RUN on a start. RUN moves back to IDLE when the enable bit is cleared, or on an underflow without auto-reload. RUN stays in RUN on a restart, on an ordinary step, or on an underflow with auto-reload.

Top module: `reload_event_timer`

## Requirements
- R1: After reset the control word reads 0, the count reads 0, `tmr_out` is 0 and `irq` is 0.
- R2: A write to address 1 stores the reload value. It leaves the count, read at address 1, unchanged until the next start.
- R3: A control write with bit 11 (trigger) and bit 10 (enable) both 1 loads the reload value and enters RUN. Bit 11 always reads 0.
- R4: Control bits [1:0] choose the source. Codes 0, 1 and 2 step the counter once every 2, 8 and 32 clocks, measured from the start. Code 3 selects event counting.
- R5: Without auto-reload (bit 5 = 0), a run started with reload value R lasts (R+1) steps. It then stops with the count equal to R.
- R6: With auto-reload (bit 5 = 1), the run continues after an underflow, and the raw output toggles on every underflow.
- R7: With source 3, control bits [4:2] = 1, 2 or 3 make rising, falling or both edges of `ext_in` decrement the counter during RUN.
- R8: With an internal source and bits [4:2] = 1, 2 or 3, the matching `ext_in` edge starts a run while enable is 1. The other edge does not start one.
- R9: With an internal source, bits [4:2] = 4 allow steps only while `ext_in` is high, and 5 only while it is low.
- R10: Bit 9 (underflow flag) is set on underflow. A control write with bit 9 = 0 clears it and one with bit 9 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R11: `irq` is 1 exactly when the flag and bit 8 (interrupt enable) are both 1.
- R12: Bit 7 inverts the output. With bit 6 (output enable) = 0, `tmr_out` stays at its inactive level, which equals bit 7.
- R13: Writing enable = 0 during a run returns the block to IDLE, and the count then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = control word, 1 = count (read) / reload (write) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ext_in | input | 1 | External event / trigger / gate input, asynchronous |
| tmr_out | output | 1 | Toggle or run-pulse output |
| irq | output | 1 | Interrupt request |

## Verification
The coincidence that matters is an underflow and a software flag-clear landing on the same clock edge. The hardware set must win, and the flag must stay 1. The bench provokes it with auto-reload on and a reload value of 1 at the fastest source. That gives an underflow exactly every four clocks after the start write, and the clearing write is placed on the fourth edge. The flag is read back as 1 and `irq` stays high. A second clearing write two cycles later, with no underflow near it, must read back 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W = 16;

    // control word field positions
    localparam int F_SRC   = 0;   // [1:0]
    localparam int F_MODE  = 2;   // [4:2]
    localparam int F_AUTO  = 5;
    localparam int F_PEN   = 6;
    localparam int F_INV   = 7;
    localparam int F_IEN   = 8;
    localparam int F_FLAG  = 9;
    localparam int F_EN    = 10;
    localparam int F_TRIG  = 11;

    localparam logic [1:0] SRC_EVENT = 2'd3;
    localparam logic [2:0] MODE_GATE_HI = 3'd4;
    localparam logic [2:0] MODE_GATE_LO = 3'd5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SH0 = 1,
    parameter int SH1 = 3,
    parameter int SH2 = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MAXSH = (SH0 > SH1) ? ((SH0 > SH2) ? SH0 : SH2)
                                       : ((SH1 > SH2) ? SH1 : SH2);

    logic [MAXSH-1:0] div_q;
    logic [3:0]       tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    for (genvar g = 0; g < 3; g++) begin : g_tap
        localparam int SH = (g == 0) ? SH0 : ((g == 1) ? SH1 : SH2);
        assign tap[g] = &div_q[SH-1:0];
    end
    assign tap[3] = 1'b0;

    assign tick = tap[sel];
endmodule

// File: rtl/tmr_pin_cond.sv
module tmr_pin_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin_async;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign level = s2_q;
    assign rise  = s2_q & ~s3_q;
    assign fall  = ~s2_q & s3_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  logic             step,
    input  logic             auto_rl,
    input  logic [REG_W-1:0] load_val,
    output logic [REG_W-1:0] count,
    output logic             running,
    output logic             uflow
);
    run_state_t       state_q, state_d;
    logic [REG_W-1:0] cnt_q;
    logic             live_step;

    assign live_step = (state_q == ST_RUN) && en && step && !start;
    assign uflow     = live_step && (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && en) state_d = ST_RUN;
            ST_RUN: begin
                if (!en)                    state_d = ST_IDLE;
                else if (start)             state_d = ST_RUN;
                else if (uflow && !auto_rl) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (start && en) cnt_q <= load_val;
        else if (uflow)     cnt_q <= load_val;
        else if (live_step) cnt_q <= cnt_q - 1'b1;
    end

    assign count   = cnt_q;
    assign running = (state_q == ST_RUN);
endmodule

// File: rtl/reload_event_timer.sv
module reload_event_timer
    import tmr_pkg::*;
#(
    parameter int SH0 = 1,
    parameter int SH1 = 3,
    parameter int SH2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             ext_in,
    output logic             tmr_out,
    output logic             irq
);
    logic [1:0]       src_q;
    logic [2:0]       mode_q;
    logic             auto_q, pen_q, inv_q, ien_q, en_q, flag_q, tog_q;
    logic [REG_W-1:0] rld_q, cnt_q, ctl_rd;
    logic             ctl_wr, rld_wr, en_eff, sw_start, ext_start, start;
    logic             tick, lvl, rise, fall, sel_edge, gate_ok, step;
    logic             run_act, uflow, raw_out;
    logic             unused_hi;

    assign unused_hi = ^bus_wdata[REG_W-1:F_TRIG+1];

    assign ctl_wr = bus_wr & ~bus_addr;
    assign rld_wr = bus_wr & bus_addr;

    // control and reload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            mode_q <= '0;
            auto_q <= 1'b0;
            pen_q  <= 1'b0;
            inv_q  <= 1'b0;
            ien_q  <= 1'b0;
            en_q   <= 1'b0;
        end else if (ctl_wr) begin
            src_q  <= bus_wdata[F_SRC+:2];
            mode_q <= bus_wdata[F_MODE+:3];
            auto_q <= bus_wdata[F_AUTO];
            pen_q  <= bus_wdata[F_PEN];
            inv_q  <= bus_wdata[F_INV];
            ien_q  <= bus_wdata[F_IEN];
            en_q   <= bus_wdata[F_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rld_q <= '0;
        else if (rld_wr) rld_q <= bus_wdata;
    end

    // sticky underflow flag: hardware set wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          flag_q <= 1'b0;
        else if (uflow)                      flag_q <= 1'b1;
        else if (ctl_wr && !bus_wdata[F_FLAG]) flag_q <= 1'b0;
    end

    // input conditioning and clock sources
    tmr_pin_cond u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(ext_in),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    tmr_prescaler #(.SH0(SH0), .SH1(SH1), .SH2(SH2)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(start),
        .sel    (src_q),
        .tick   (tick)
    );

    assign sel_edge  = ~mode_q[2] & ((mode_q[0] & rise) | (mode_q[1] & fall));
    assign gate_ok   = (mode_q == MODE_GATE_HI) ? lvl :
                       (mode_q == MODE_GATE_LO) ? ~lvl : 1'b1;
    assign step      = (src_q == SRC_EVENT) ? sel_edge : (tick & gate_ok);

    assign en_eff    = ctl_wr ? bus_wdata[F_EN] : en_q;
    assign sw_start  = ctl_wr & bus_wdata[F_TRIG] & bus_wdata[F_EN];
    assign ext_start = en_q & (src_q != SRC_EVENT) & sel_edge;
    assign start     = sw_start | ext_start;

    tmr_count_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .en      (en_eff),
        .step    (step),
        .auto_rl (auto_q),
        .load_val(rld_q),
        .count   (cnt_q),
        .running (run_act),
        .uflow   (uflow)
    );

    // output shaping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tog_q <= 1'b0;
        else if (start) tog_q <= 1'b0;
        else if (uflow) tog_q <= ~tog_q;
    end

    always_comb begin
        raw_out = auto_q ? tog_q : run_act;
        tmr_out = pen_q ? (raw_out ^ inv_q) : inv_q;
        irq     = flag_q & ien_q;
    end

    // read path
    always_comb begin
        ctl_rd            = '0;
        ctl_rd[F_SRC+:2]  = src_q;
        ctl_rd[F_MODE+:3] = mode_q;
        ctl_rd[F_AUTO]    = auto_q;
        ctl_rd[F_PEN]     = pen_q;
        ctl_rd[F_INV]     = inv_q;
        ctl_rd[F_IEN]     = ien_q;
        ctl_rd[F_FLAG]    = flag_q;
        ctl_rd[F_EN]      = en_q;
        bus_rdata         = bus_addr ? cnt_q : ctl_rd;
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        is_run,
    input logic [15:0] count,
    input logic [15:0] reload_q,
    input logic        uflow,
    input logic        step,
    input logic        start,
    input logic        flag,
    input logic        auto_rl,
    input logic        en,
    input logic        ctl_wr
);
    assert_load_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && en) |=> (count == $past(reload_q)));

    assert_step_decrements_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_run && en && step && !start && count != 16'd0) |=> (count == $past(count) - 16'd1));

    assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !auto_rl) |=> !is_run);

    assert_reload_on_uflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> (count == $past(reload_q)));

    assert_auto_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && auto_rl && !ctl_wr) |=> is_run);

    assert_flag_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> flag);

    assert_idle_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_run && !start) |=> $stable(count));
endmodule

bind reload_event_timer tmr_checker u_tmr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_run  (run_act),
    .count   (cnt_q),
    .reload_q(rld_q),
    .uflow   (uflow),
    .step    (step),
    .start   (start),
    .flag    (flag_q),
    .auto_rl (auto_q),
    .en      (en_eff),
    .ctl_wr  (ctl_wr)
);

// File: tb/test_reload_event_timer.sv
module test_reload_event_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_in = 1'b0;
    logic        tmr_out, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reload_event_timer i_reload_event_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .tmr_out(tmr_out), .irq(irq)
    );

    // one-shot runs: source, reload value, invert, expected pulse width
    localparam int NV = 5;
    localparam int V_SRC [NV] = '{0, 1, 2, 0, 0};
    localparam int V_RLD [NV] = '{3, 1, 0, 0, 10};
    localparam int V_INV [NV] = '{0, 0, 0, 1, 1};
    localparam int V_WID [NV] = '{8, 16, 32, 2, 22};

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl(int src, int mode, bit au, bit pen, bit inv,
                                        bit ien, bit flg, bit en, bit trg);
        logic [15:0] w;
        w = '0;
        w[1:0] = src[1:0]; w[4:2] = mode[2:0]; w[5] = au; w[6] = pen; w[7] = inv;
        w[8] = ien; w[9] = flg; w[10] = en; w[11] = trg;
        return w;
    endfunction

    task automatic wr(bit a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic rd(bit a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_addr = 1'b0;
    endtask

    task automatic pulse_in(int n);
        for (int k = 0; k < n; k++) begin
            ext_in = 1'b1; repeat (4) @(negedge clk);
            ext_in = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        int w, tg;
        bit pv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, d); chk("R1 ctl", d, 0);
        rd(1'b1, d); chk("R1 count", d, 0);
        chk("R1 out", tmr_out, 0);
        chk("R1 irq", irq, 0);

        // R2 reload write does not touch count
        wr(1'b1, 16'd77);
        rd(1'b1, d); chk("R2 count after reload write", d, 0);

        // vector table: one-shot pulse width (R4, R5, R12)
        for (int i = 0; i < NV; i++) begin
            wr(1'b1, 16'(V_RLD[i]));
            wr(1'b0, ctl(V_SRC[i], 0, 0, 1, V_INV[i][0], 0, 0, 1, 1));
            w = 0;
            while (tmr_out != V_INV[i][0] && w < 1000) begin
                w++; @(negedge clk);
            end
            chk("R4 pulse width", w, V_WID[i]);
            rd(1'b1, d); chk("R5 count after stop", d, V_RLD[i]);
            rd(1'b0, d); chk("R10 flag after run", d[9], 1);
            chk("R3 trigger bit reads 0", d[11], 0);
        end

        // R12 output disabled holds inactive level
        wr(1'b1, 16'd3);
        wr(1'b0, ctl(0, 0, 0, 0, 1, 0, 0, 1, 1));
        w = 0;
        for (int k = 0; k < 12; k++) begin
            if (tmr_out != 1'b1) w++;
            @(negedge clk);
        end
        chk("R12 disabled output level", w, 0);

        // R6 auto-reload toggling: R=1, div 2 -> underflow every 4 clocks
        wr(1'b1, 16'd1);
        wr(1'b0, ctl(0, 0, 1, 1, 0, 0, 0, 1, 1));
        tg = 0; pv = tmr_out;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tmr_out != pv) tg++;
            pv = tmr_out;
        end
        chk("R6 toggles in 40 clocks", tg, 10);
        wr(1'b0, ctl(0, 0, 1, 1, 0, 0, 0, 0, 0));

        // R10/R11 collision: clearing write on an underflow edge
        wr(1'b0, ctl(0, 0, 1, 1, 0, 1, 0, 1, 1));
        repeat (3) @(negedge clk);
        wr(1'b0, ctl(0, 0, 1, 1, 0, 1, 0, 1, 0));
        rd(1'b0, d); chk("R10 set beats clear", d[9], 1);
        chk("R11 irq with flag", irq, 1);
        @(negedge clk);
        wr(1'b0, ctl(0, 0, 1, 1, 0, 1, 0, 1, 0));
        rd(1'b0, d); chk("R10 clear away from underflow", d[9], 0);
        chk("R11 irq after clear", irq, 0);
        @(negedge clk);
        wr(1'b0, ctl(0, 0, 1, 1, 0, 1, 1, 1, 0));
        repeat (4) @(negedge clk);
        wr(1'b0, ctl(0, 0, 1, 1, 0, 1, 1, 1, 0));
        rd(1'b0, d); chk("R10 write 1 keeps flag", d[9], 1);
        wr(1'b0, ctl(0, 0, 1, 1, 0, 0, 1, 0, 0));
        chk("R11 irq masked", irq, 0);

        // R7 event counting
        wr(1'b1, 16'd5);
        wr(1'b0, ctl(3, 1, 0, 1, 0, 0, 0, 1, 1));
        pulse_in(4);
        rd(1'b1, d); chk("R7 rising edges", d, 1);
        wr(1'b0, ctl(3, 2, 0, 1, 0, 0, 0, 1, 1));
        pulse_in(4);
        rd(1'b1, d); chk("R7 falling edges", d, 1);
        wr(1'b0, ctl(3, 3, 0, 1, 0, 0, 0, 1, 1));
        pulse_in(2);
        rd(1'b1, d); chk("R7 both edges", d, 1);
        wr(1'b1, 16'd2);
        wr(1'b0, ctl(3, 1, 0, 1, 0, 0, 0, 1, 1));
        pulse_in(3);
        rd(1'b0, d); chk("R7 event underflow flag", d[9], 1);
        chk("R5 event one-shot ended", tmr_out, 0);

        // R8 external trigger on rising edge
        wr(1'b1, 16'd3);
        wr(1'b0, ctl(0, 1, 0, 1, 0, 0, 0, 1, 0));
        repeat (6) @(negedge clk);
        chk("R8 no run before edge", tmr_out, 0);
        ext_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 run after rising edge", tmr_out, 1);
        repeat (20) @(negedge clk);
        chk("R8 run ended", tmr_out, 0);
        ext_in = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 falling edge ignored", tmr_out, 0);

        // R9 gate high, then gate low
        wr(1'b1, 16'd100);
        wr(1'b0, ctl(0, 4, 0, 1, 0, 0, 0, 1, 1));
        repeat (20) @(negedge clk);
        rd(1'b1, d); chk("R9 gate closed", d, 100);
        ext_in = 1'b1;
        repeat (20) @(negedge clk);
        ext_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(1'b1, d); chk("R9 gate high 20 clocks", d, 90);
        wr(1'b0, ctl(0, 5, 0, 1, 0, 0, 0, 1, 1));
        repeat (20) @(negedge clk);
        rd(1'b1, d); chk("R9 gate low counts", d, 90);

        // R13 enable cleared halts
        wr(1'b0, ctl(0, 0, 0, 1, 0, 0, 0, 1, 1));
        repeat (10) @(negedge clk);
        wr(1'b0, ctl(0, 0, 0, 1, 0, 0, 0, 0, 0));
        rd(1'b1, d); w = d;
        chk("R13 out low after halt", tmr_out, 0);
        repeat (20) @(negedge clk);
        rd(1'b1, d); chk("R13 count holds", d, w);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule